// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory DMA Engine

This block copies data between two memory locations on behalf of software, using two independent channels that share one memory master port. Software programs each channel through a small register port: a source address, a destination address, a 24-bit unit count and a control word. The control word selects the unit size, how each address moves after every unit, whether the channel paces itself or waits for an external request line, and whether completion raises an interrupt. A shared operation register carries the master enable, and each channel has its own interrupt vector register.

Each unit is moved as one read from the source followed by one write to the destination. Only one memory access is in flight at any time. When both channels want the port, channel 0 wins. When a channel's count reaches zero, it sets its end flag and, if enabled, asserts an interrupt request carrying that channel's vector and the priority level supplied on an input. Software clears the end flag by writing 0 to it, which also withdraws the request.

Register word indices on `reg_addr`: 0 to 3 are channel 0 source, destination, count and control; 4 to 7 are the same for channel 1; 8 and 9 are the vectors of channels 0 and 1; 10 is the operation register.

Top module: `dma2ch`

## Requirements
- R1: Every register reads back through `reg_rd` one cycle later on `reg_rdata`. After reset all registers read 0, and `irq_req` and `mem_req` are low.
- R2: The count register keeps only the low 24 bits of a write. It decreases by exactly one per unit moved.
- R3: Control bits 11:10 choose the unit size: 0 is one byte, 1 is two bytes, 2 is four bytes. Code 3 behaves as four bytes. The size is presented on `mem_size` as 0, 1 or 2.
- R4: Control bit 12 increments the source and bit 13 decrements it, in steps of the unit size. Bits 14 and 15 do the same for the destination. When neither or both bits of a pair are set, that address stays fixed.
- R5: A channel is started only by a write to its control word or to the operation register. At that moment its enable (control bit 0) must be 1, its end flag (control bit 1) must be 0, and the master enable (operation bit 0) must be 1. Otherwise no memory access takes place.
- R6: With control bit 9 set (self-paced), a started channel moves units back to back until its count is zero.
- R7: With control bit 9 clear, a started channel moves exactly one unit per rising edge of its `dreq` line. A line held high counts once.
- R8: When a started channel's count is zero, it sets its end flag and stops. A channel started with a count of 0 finishes with no memory access.
- R9: While a channel's end flag and interrupt enable (control bit 2) are both set, `irq_req` is high. `irq_vec` then carries the low 7 bits of that channel's vector register and `irq_lvl` the `irq_prio` input. Writing 0 to the end flag drops the request, and writing 1 to it has no effect.
- R10: When both channels are ready, channel 0 receives the memory port first.
- R11: Each unit is one read followed by one write. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dreq | input | 2 | External request line per channel |
| irq_prio | input | 4 | Priority level passed out with the interrupt |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 7 | Vector of the requesting channel |
| irq_lvl | output | 4 | Priority level of the request |
| mem_req | output | 1 | Memory access request, held until acknowledge |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_size | output | 2 | Access size: 0 byte, 1 two bytes, 2 four bytes |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, right aligned |
| mem_rdata | input | 32 | Read data, right aligned |
| mem_ack | input | 1 | One-cycle completion of the current access |

## Verification
A wrong count, address step or arming flag shows up at the memory port within one unit, as an access to the wrong address, an extra access or a missing one. It also shows in the register readback of the final source, destination and count. A stuck or missed end flag appears on `irq_req` one cycle after the count empties, and in the control word readback. Priority and pacing faults are seen at the first read address after a start and in the count that remains after each `dreq` edge.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  localparam int NCH  = 2;
  localparam int RA_W = 4;

  localparam logic [RA_W-1:0] RA_VEC_BASE = 4'd8;
  localparam logic [RA_W-1:0] RA_OPR      = 4'd10;

  // control word bit positions
  localparam int CB_DE   = 0;
  localparam int CB_TE   = 1;
  localparam int CB_IE   = 2;
  localparam int CB_AR   = 9;
  localparam int CB_SZ   = 10;
  localparam int CB_SINC = 12;
  localparam int CB_SDEC = 13;
  localparam int CB_DINC = 14;
  localparam int CB_DDEC = 15;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} mv_state_t;

  // 16-byte code is carried out as a 4-byte unit
  function automatic logic [1:0] eff_size(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
  import dma2ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          op_wr,
  input  logic          op_bit,
  input  logic          master_en,
  input  logic          dreq,
  input  logic          grant,
  input  logic          unit_done,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic [15:0]   ctl_o,
  output logic [1:0]    size_o,
  output logic          ready_o,
  output logic          irq_o
);
  logic [AW-1:0] src_r, dst_r, step;
  logic [CW-1:0] cnt_r;
  logic [15:0]   ctl_r;
  logic          te_r, armed_r, pend_r, dreq_q;
  logic          ctl_wr, live, finish, arm_now;
  logic [1:0]    sz;

  function automatic logic [AW-1:0] move(input logic [AW-1:0] a, input logic dec,
                                         input logic inc, input logic [AW-1:0] s);
    if (inc && !dec) return a + s;
    if (dec && !inc) return a - s;
    return a;
  endfunction

  always_comb begin
    sz      = eff_size(ctl_r[CB_SZ +: 2]);
    step    = AW'(1) << sz;
    ctl_wr  = wr_en && (wr_idx == 2'd3);
    live    = armed_r && ctl_r[CB_DE] && master_en;
    finish  = live && (cnt_r == '0);
    arm_now = (ctl_wr && wr_data[CB_DE] && !(te_r && wr_data[CB_TE]) && master_en) ||
              (op_wr && op_bit && ctl_r[CB_DE] && !te_r);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_r   <= '0;
      dst_r   <= '0;
      cnt_r   <= '0;
      ctl_r   <= '0;
      te_r    <= 1'b0;
      armed_r <= 1'b0;
      pend_r  <= 1'b0;
      dreq_q  <= 1'b0;
    end else begin
      dreq_q <= dreq;
      pend_r <= (pend_r && !grant) || (dreq && !dreq_q && live && !ctl_r[CB_AR]);

      if (arm_now) armed_r <= 1'b1;
      else if (finish || !ctl_r[CB_DE] || !master_en) armed_r <= 1'b0;

      if (finish) te_r <= 1'b1;
      else if (ctl_wr && !wr_data[CB_TE]) te_r <= 1'b0;

      if (ctl_wr) ctl_r <= wr_data[15:0] & ~16'h0002;

      if (wr_en && wr_idx == 2'd0) src_r <= wr_data[AW-1:0];
      else if (unit_done) src_r <= move(src_r, ctl_r[CB_SDEC], ctl_r[CB_SINC], step);

      if (wr_en && wr_idx == 2'd1) dst_r <= wr_data[AW-1:0];
      else if (unit_done) dst_r <= move(dst_r, ctl_r[CB_DDEC], ctl_r[CB_DINC], step);

      if (wr_en && wr_idx == 2'd2) cnt_r <= wr_data[CW-1:0];
      else if (unit_done) cnt_r <= cnt_r - 1'b1;
    end
  end

  assign src_o   = src_r;
  assign dst_o   = dst_r;
  assign cnt_o   = cnt_r;
  assign ctl_o   = ctl_r | {14'b0, te_r, 1'b0};
  assign size_o  = sz;
  assign ready_o = live && (cnt_r != '0) && (ctl_r[CB_AR] || pend_r);
  assign irq_o   = te_r && ctl_r[CB_IE];
endmodule

// File: rtl/dma2ch_mover.sv
module dma2ch_mover
  import dma2ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ready,
  input  logic [AW-1:0]  src_i [NCH],
  input  logic [AW-1:0]  dst_i [NCH],
  input  logic [1:0]     size_i [NCH],
  output logic [NCH-1:0] grant,
  output logic [NCH-1:0] done,
  output logic           mem_req,
  output logic           mem_we,
  output logic [1:0]     mem_size,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack
);
  mv_state_t     state;
  logic [CH_W-1:0] sel, cur;
  logic [AW-1:0] dst_q;

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (ready[c]) sel = CH_W'(c);
    end
  end

  assign grant = (state == ST_IDLE && |ready) ? (NCH'(1) << sel) : '0;
  assign done  = (state == ST_WR && mem_ack)  ? (NCH'(1) << cur) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur       <= '0;
      dst_q     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= 2'd0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (|ready) begin
          cur      <= sel;
          dst_q    <= dst_i[sel];
          mem_addr <= src_i[sel];
          mem_size <= size_i[sel];
          mem_we   <= 1'b0;
          mem_req  <= 1'b1;
          state    <= ST_RD;
        end
        ST_RD: if (mem_ack) begin
          mem_addr  <= dst_q;
          mem_wdata <= mem_rdata;
          mem_we    <= 1'b1;
          state     <= ST_WR;
        end
        ST_WR: if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 32,
  parameter int VW = 7,
  parameter int LW = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NCH-1:0]  dreq,
  input  logic [LW-1:0]   irq_prio,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec,
  output logic [LW-1:0]   irq_lvl,
  output logic            mem_req,
  output logic            mem_we,
  output logic [1:0]      mem_size,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack
);
  logic [AW-1:0]  src_w [NCH];
  logic [AW-1:0]  dst_w [NCH];
  logic [CW-1:0]  cnt_w [NCH];
  logic [15:0]    ctl_w [NCH];
  logic [1:0]     size_w [NCH];
  logic [VW-1:0]  vec_r [NCH];
  logic [NCH-1:0] ready_w, grant_w, done_w, irq_w, te_bits, ie_bits;
  logic           master_en, ch_hit, op_wr;
  logic [CH_W-1:0] ch_sel;
  logic [1:0]     reg_idx;
  logic [VW-1:0]  vec_pick;

  assign ch_hit  = reg_addr < RA_W'(4 * NCH);
  assign ch_sel  = reg_addr[2 +: CH_W];
  assign reg_idx = reg_addr[1:0];
  assign op_wr   = reg_wr && (reg_addr == RA_OPR);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma2ch_chan #(.AW(AW), .CW(CW), .DW(DW)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (reg_wr && ch_hit && (ch_sel == CH_W'(c))),
      .wr_idx    (reg_idx),
      .wr_data   (reg_wdata),
      .op_wr     (op_wr),
      .op_bit    (reg_wdata[0]),
      .master_en (master_en),
      .dreq      (dreq[c]),
      .grant     (grant_w[c]),
      .unit_done (done_w[c]),
      .src_o     (src_w[c]),
      .dst_o     (dst_w[c]),
      .cnt_o     (cnt_w[c]),
      .ctl_o     (ctl_w[c]),
      .size_o    (size_w[c]),
      .ready_o   (ready_w[c]),
      .irq_o     (irq_w[c])
    );
    assign te_bits[c] = ctl_w[c][CB_TE];
    assign ie_bits[c] = ctl_w[c][CB_IE];

    always_ff @(posedge clk) begin
      if (rst) vec_r[c] <= '0;
      else if (reg_wr && reg_addr == RA_VEC_BASE + RA_W'(c)) vec_r[c] <= reg_wdata[VW-1:0];
    end
  end

  dma2ch_mover #(.AW(AW), .DW(DW)) u_mover (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready_w),
    .src_i     (src_w),
    .dst_i     (dst_w),
    .size_i    (size_w),
    .grant     (grant_w),
    .done      (done_w),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );

  always_comb begin
    vec_pick = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (irq_w[c]) vec_pick = vec_r[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master_en <= 1'b0;
      reg_rdata <= '0;
      irq_req   <= 1'b0;
      irq_vec   <= '0;
      irq_lvl   <= '0;
    end else begin
      if (op_wr) master_en <= reg_wdata[0];
      irq_req <= |irq_w;
      irq_vec <= vec_pick;
      irq_lvl <= irq_prio;
      if (reg_rd) begin
        reg_rdata <= '0;
        if (ch_hit) begin
          case (reg_idx)
            2'd0:    reg_rdata <= DW'(src_w[ch_sel]);
            2'd1:    reg_rdata <= DW'(dst_w[ch_sel]);
            2'd2:    reg_rdata <= DW'(cnt_w[ch_sel]);
            default: reg_rdata <= DW'(ctl_w[ch_sel]);
          endcase
        end else if (reg_addr == RA_OPR) begin
          reg_rdata <= DW'(master_en);
        end else begin
          for (int c = 0; c < NCH; c++) begin
            if (reg_addr == RA_VEC_BASE + RA_W'(c)) reg_rdata <= DW'(vec_r[c]);
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma2ch_chk.sv
module dma2ch_chk
  import dma2ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_wr,
  input logic           mem_req,
  input logic           mem_ack,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic           master_en,
  input logic [NCH-1:0] te_bits,
  input logic [NCH-1:0] ie_bits,
  input logic           irq_req,
  input logic [CW-1:0]  cnt0
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> !mem_we); // R11

  AST_START_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> master_en); // R5

  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(te_bits[0]) |-> cnt0 == '0); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr) && !$stable(cnt0) |-> cnt0 == CW'($past(cnt0) - 1'b1)); // R2

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(|(te_bits & ie_bits))); // R9
endmodule

bind dma2ch dma2ch_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .master_en (master_en),
  .te_bits   (te_bits),
  .ie_bits   (ie_bits),
  .irq_req   (irq_req),
  .cnt0      (cnt_w[0])
);

// File: tb/tb_dma2ch.sv
`timescale 1ns/1ps
module tb_dma2ch;
  localparam time CYC = 20ns;

  localparam logic [3:0] A_SRC0 = 4'd0, A_DST0 = 4'd1, A_CNT0 = 4'd2, A_CTL0 = 4'd3;
  localparam logic [3:0] A_SRC1 = 4'd4, A_DST1 = 4'd5, A_CNT1 = 4'd6, A_CTL1 = 4'd7;
  localparam logic [3:0] A_VEC0 = 4'd8, A_OPR = 4'd10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0]  dreq = '0;
  logic [3:0]  irq_prio = '0, irq_lvl;
  logic        irq_req;
  logic [6:0]  irq_vec;
  logic        mem_req, mem_we, mem_ack;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  int rd_count = 0, wr_count = 0;
  logic [31:0] first_rd = '0;
  bit got_first = 1'b0;
  logic [7:0] mem [256];

  always #(CYC/2) clk = ~clk;

  dma2ch dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .irq_prio(irq_prio),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .mem_req(mem_req),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // memory model: acknowledges one cycle after a request, little-endian bytes
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        wr_count++;
        for (int b = 0; b < (1 << mem_size); b++)
          mem[8'(mem_addr[7:0] + b)] = mem_wdata[8*b +: 8];
      end else begin
        rd_count++;
        if (!got_first) begin
          first_rd = mem_addr;
          got_first = 1'b1;
        end
        mem_rdata <= {mem[8'(mem_addr[7:0] + 3)], mem[8'(mem_addr[7:0] + 2)],
                      mem[8'(mem_addr[7:0] + 1)], mem[mem_addr[7:0]]};
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(input int base, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) mem[8'(base + i)] = seed + 8'(i);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(A_CTL0, v); chk("R1", "ctl0 after reset", v, 0);
    rd_reg(A_CNT1, v); chk("R1", "cnt1 after reset", v, 0);
    chk("R1", "irq_req after reset", 32'(irq_req), 0);
    chk("R1", "mem_req after reset", 32'(mem_req), 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr_reg(A_SRC1, 32'h1234_5678); rd_reg(A_SRC1, v); chk("R1", "src1 readback", v, 32'h1234_5678);
    wr_reg(A_CNT1, 32'hAB00_0005); rd_reg(A_CNT1, v); chk("R2", "count upper bits dropped", v, 32'h5);
    wr_reg(A_CNT1, 0);
  endtask

  task automatic t_auto_word();
    logic [31:0] v;
    int w0 = wr_count;
    fill(8'h10, 12, 8'h30);
    wr_reg(A_OPR, 1);
    wr_reg(A_SRC0, 32'h10); wr_reg(A_DST0, 32'h40); wr_reg(A_CNT0, 3);
    wr_reg(A_CTL0, 32'h5A01);
    idle(60);
    for (int i = 0; i < 12; i++) chk("R6", "word copy byte", 32'(mem[8'(8'h40 + i)]), 32'(8'h30 + i));
    chk("R6", "unit writes", 32'(wr_count - w0), 3);
    rd_reg(A_SRC0, v); chk("R4", "src after inc", v, 32'h1C);
    rd_reg(A_DST0, v); chk("R4", "dst after inc", v, 32'h4C);
    rd_reg(A_CNT0, v); chk("R2", "count drained", v, 0);
    rd_reg(A_CTL0, v); chk("R8", "end flag", v & 2, 2);
    chk("R9", "no irq without enable", 32'(irq_req), 0);
    wr_reg(A_CTL0, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    irq_prio = 4'hA;
    wr_reg(A_VEC0, 32'h1D5);
    rd_reg(A_VEC0, v); chk("R9", "vector keeps 7 bits", v, 32'h55);
    mem[8'h18] = 8'h77;
    wr_reg(A_SRC0, 32'h18); wr_reg(A_DST0, 32'h50); wr_reg(A_CNT0, 1);
    wr_reg(A_CTL0, 32'h5205);
    idle(20);
    chk("R9", "irq raised", 32'(irq_req), 1);
    chk("R9", "irq vector", 32'(irq_vec), 32'h55);
    chk("R9", "irq level", 32'(irq_lvl), 32'hA);
    wr_reg(A_CTL0, 32'h5206);
    idle(3);
    chk("R9", "writing 1 to end flag keeps irq", 32'(irq_req), 1);
    wr_reg(A_CTL0, 32'h5204);
    idle(3);
    chk("R9", "irq dropped after clear", 32'(irq_req), 0);
    wr_reg(A_CTL0, 0);
  endtask

  task automatic t_byte_dec();
    logic [31:0] v;
    fill(8'h20, 4, 8'hA0);
    mem[8'h60] = 0; mem[8'h61] = 0;
    wr_reg(A_SRC0, 32'h23); wr_reg(A_DST0, 32'h60); wr_reg(A_CNT0, 2);
    wr_reg(A_CTL0, 32'h2201);
    idle(40);
    chk("R4", "fixed dst holds last byte", 32'(mem[8'h60]), 32'hA2);
    chk("R3", "byte unit leaves next byte", 32'(mem[8'h61]), 0);
    rd_reg(A_SRC0, v); chk("R4", "src after dec", v, 32'h21);
    rd_reg(A_DST0, v); chk("R4", "dst fixed", v, 32'h60);
    wr_reg(A_CTL0, 0);
  endtask

  task automatic t_half_both();
    logic [31:0] v;
    fill(8'h30, 4, 8'h11);
    mem[8'h70] = 0; mem[8'h71] = 0; mem[8'h72] = 0;
    wr_reg(A_SRC0, 32'h30); wr_reg(A_DST0, 32'h70); wr_reg(A_CNT0, 2);
    wr_reg(A_CTL0, 32'hD601);
    idle(40);
    chk("R3", "half unit low byte", 32'(mem[8'h70]), 32'h13);
    chk("R3", "half unit high byte", 32'(mem[8'h71]), 32'h14);
    chk("R3", "half unit stops", 32'(mem[8'h72]), 0);
    rd_reg(A_DST0, v); chk("R4", "both dst bits keep address", v, 32'h70);
    rd_reg(A_SRC0, v); chk("R4", "src step of two", v, 32'h34);
    wr_reg(A_CTL0, 0);
  endtask

  task automatic t_size3();
    logic [31:0] v;
    fill(8'h80, 4, 8'hC1);
    wr_reg(A_SRC0, 32'h80); wr_reg(A_DST0, 32'h90); wr_reg(A_CNT0, 1);
    wr_reg(A_CTL0, 32'h5E01);
    idle(20);
    chk("R3", "code 3 moves 4 bytes", {mem[8'h93], mem[8'h92], mem[8'h91], mem[8'h90]}, 32'hC4C3C2C1);
    rd_reg(A_SRC0, v); chk("R3", "code 3 step", v, 32'h84);
    wr_reg(A_CTL0, 0);
  endtask

  task automatic t_master();
    logic [31:0] v;
    int w0;
    wr_reg(A_OPR, 0);
    w0 = wr_count;
    wr_reg(A_SRC0, 32'h10); wr_reg(A_DST0, 32'hE0); wr_reg(A_CNT0, 1);
    wr_reg(A_CTL0, 32'h5A01);
    idle(20);
    chk("R5", "no access with master off", 32'(wr_count - w0), 0);
    rd_reg(A_CNT0, v); chk("R5", "count kept with master off", v, 1);
    wr_reg(A_OPR, 1);
    idle(20);
    chk("R5", "operation write starts channel", 32'(wr_count - w0), 1);
    rd_reg(A_CNT0, v); chk("R5", "count after start", v, 0);
  endtask

  task automatic t_te_block();
    logic [31:0] v;
    int w0 = wr_count;
    wr_reg(A_CNT0, 2);
    wr_reg(A_CTL0, 32'h5A03);
    idle(20);
    chk("R5", "set end flag blocks start", 32'(wr_count - w0), 0);
    rd_reg(A_CNT0, v); chk("R5", "count kept while end set", v, 2);
    wr_reg(A_CTL0, 0);
  endtask

  task automatic t_dreq();
    logic [31:0] v;
    wr_reg(A_SRC1, 32'hA0); wr_reg(A_DST1, 32'hB0); wr_reg(A_CNT1, 3);
    wr_reg(A_CTL1, 32'h5401);
    idle(20);
    rd_reg(A_CNT1, v); chk("R7", "no unit without request", v, 3);
    @(negedge clk); dreq[1] = 1'b1; @(negedge clk); dreq[1] = 1'b0;
    idle(20);
    rd_reg(A_CNT1, v); chk("R7", "one unit per pulse", v, 2);
    @(negedge clk); dreq[1] = 1'b1; idle(30);
    rd_reg(A_CNT1, v); chk("R7", "held line counts once", v, 1);
    @(negedge clk); dreq[1] = 1'b0; idle(2);
    @(negedge clk); dreq[1] = 1'b1; @(negedge clk); dreq[1] = 1'b0;
    idle(20);
    rd_reg(A_CNT1, v); chk("R7", "last unit", v, 0);
    rd_reg(A_CTL1, v); chk("R8", "end flag after request units", v & 2, 2);
    wr_reg(A_CTL1, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int w0 = wr_count;
    wr_reg(A_CNT1, 0);
    wr_reg(A_CTL1, 32'h0201);
    idle(10);
    chk("R8", "zero count makes no access", 32'(wr_count - w0), 0);
    rd_reg(A_CTL1, v); chk("R8", "zero count ends at once", v & 2, 2);
    wr_reg(A_CTL1, 0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wr_reg(A_OPR, 0);
    wr_reg(A_SRC0, 32'hC0); wr_reg(A_DST0, 32'hD0); wr_reg(A_CNT0, 1);
    wr_reg(A_SRC1, 32'hC8); wr_reg(A_DST1, 32'hD8); wr_reg(A_CNT1, 1);
    wr_reg(A_CTL0, 32'h5A01); wr_reg(A_CTL1, 32'h5A01);
    got_first = 1'b0;
    wr_reg(A_OPR, 1);
    idle(30);
    chk("R10", "channel 0 served first", first_rd, 32'hC0);
    rd_reg(A_CNT1, v); chk("R10", "channel 1 served after", v, 0);
    chk("R11", "reads match writes", 32'(rd_count), 32'(wr_count));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_auto_word();
    t_irq();
    t_byte_dec();
    t_half_both();
    t_size3();
    t_master();
    t_te_block();
    t_dreq();
    t_zero();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule